// File: doc/BRIEF.md
# Two-Phase Blink Pattern Selector

This block decides the logic level of nine open-drain style outputs from two stored patterns. One pattern is the phase-zero image and the other the phase-one image. A byte register holds the low eight bits of each pattern. The ninth output takes its pair of bits from separate configuration fields. A two-bit control field turns blinking on and supplies a software flip flag.

While blinking is on, the active phase is the exclusive-OR of the synchronized external blink pin and the flip flag. While blinking is off, phase zero alone drives the outputs and the flip flag has no effect. A pattern bit of 1 releases its output to high impedance, reported as 1 on `port_rel`. A pattern bit of 0 pulls the output low, reported as 0.

The synchronized pin level is also returned as a status bit. The pin can then serve as a general-purpose input whether or not blinking is on. The register file that holds the patterns sits outside this block. After reset that register file holds all ones, so every output is released.

Top module: `blink_phase_selector`

## Requirements
- R1: With control bit 0 (blink enable) low, `port_rel` equals `{hi_phase0, phase0_byte}` for every value of control bit 1 (flip) and of the blink pin.
- R2: With control bit 0 high, the phase is the synchronized pin level XOR control bit 1. Phase 1 selects `{hi_phase1, phase1_byte}` and phase 0 selects `{hi_phase0, phase0_byte}`.
- R3: Output bit 8 obeys the same static and blink selection as bits 7..0, using `hi_phase0` in phase 0 and `hi_phase1` in phase 1.
- R4: Each output bit copies its selected pattern bit unchanged: 1 means released (high impedance) and 0 means driven low. A change of a pattern input shows on `port_rel` in the same cycle.
- R5: `blink_status` equals the blink pin level sampled two rising clock edges earlier, with blinking on or off.
- R6: A pin edge set up before rising edge k changes `blink_status` and the selected phase just after edge k+1, and not after edge k. A pin level held for at least two clocks is never dropped.
- R7: While reset is low, the next rising edge clears `blink_status` to 0. With blinking on and the flip flag 0, the outputs then show the phase-0 pattern even if the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blink_pin | input | 1 | Asynchronous external blink level |
| ctl | input | 2 | bit 0 blink enable, bit 1 software flip flag |
| phase0_byte | input | 8 | Phase-0 pattern for outputs 7..0 |
| phase1_byte | input | 8 | Phase-1 pattern for outputs 7..0 |
| hi_phase0 | input | 1 | Phase-0 bit for output 8 |
| hi_phase1 | input | 1 | Phase-1 bit for output 8 |
| port_rel | output | 9 | Output levels, 1 = released, 0 = pulled low |
| blink_status | output | 1 | Synchronized blink pin level |

## Verification
The assertions assume that `blink_pin` may change at any time. They also assume that the control and pattern inputs come from a register file in the same clock domain.

The bench changes the pin only at falling clock edges and holds each level for at least two clocks. The other inputs also change only at falling edges. Combinational checks are taken one time step after the inputs settle. The pin-latency checks are sampled at falling edges, counted from the edge that follows the pin change.

// File: rtl/blink_sel_pkg.sv
// Package: shared phase encoding and control-field bit positions for the
// two-phase blink selector. Assumes nothing beyond IEEE 1800-2017.
package blink_sel_pkg;
    typedef enum logic {
        PH_ZERO = 1'b0,
        PH_ONE  = 1'b1
    } phase_e;

    localparam int CTL_W        = 2;
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_FLIP_BIT = 1;
endpackage

// File: rtl/blink_sync.sv
// Module: blink_sync
// Multi-stage synchronizer for one asynchronous level. Output lags the input
// by STAGES rising edges. Assumes STAGES >= 2 and synchronous active-low reset
// clearing every stage to 0.
module blink_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the sampled level one stage per clock; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/blink_phase_calc.sv
// Module: blink_phase_calc
// Derives the active blink phase from the synchronized pin level and the
// control field. Assumes the pin level is already in the clock domain.
module blink_phase_calc
    import blink_sel_pkg::*;
(
    input  logic             pin_lvl,
    input  logic [CTL_W-1:0] ctl,
    output phase_e           phase
);
    logic en_bit;
    logic flip_bit;

    assign en_bit   = ctl[CTL_EN_BIT];
    assign flip_bit = ctl[CTL_FLIP_BIT];

    // Phase is pin XOR flip when enabled, else forced to phase zero.
    always_comb begin
        if (en_bit && (pin_lvl ^ flip_bit)) phase = PH_ONE;
        else                                phase = PH_ZERO;
    end
endmodule

// File: rtl/blink_port_mux.sv
// Module: blink_port_mux
// Per-output two-way selector between the phase-zero and phase-one images.
// Purely combinational; assumes both images are stable register outputs.
module blink_port_mux
    import blink_sel_pkg::*;
#(
    parameter int PORTS = 9
) (
    input  phase_e           phase,
    input  logic [PORTS-1:0] img0,
    input  logic [PORTS-1:0] img1,
    output logic [PORTS-1:0] sel
);
    for (genvar i = 0; i < PORTS; i++) begin : g_port
        // Pick this output's bit from the image of the active phase.
        always_comb begin
            sel[i] = (phase == PH_ONE) ? img1[i] : img0[i];
        end
    end
endmodule

// File: rtl/blink_phase_selector.sv
// Module: blink_phase_selector (top)
// Selects nine output levels from two patterns by blink phase and reports the
// synchronized blink pin. Assumes pattern and control inputs come from a
// register file in the clk domain; blink_pin may be asynchronous.
module blink_phase_selector
    import blink_sel_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int EXTRA_W     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      blink_pin,
    input  logic [CTL_W-1:0]          ctl,
    input  logic [BYTE_W-1:0]         phase0_byte,
    input  logic [BYTE_W-1:0]         phase1_byte,
    input  logic [EXTRA_W-1:0]        hi_phase0,
    input  logic [EXTRA_W-1:0]        hi_phase1,
    output logic [BYTE_W+EXTRA_W-1:0] port_rel,
    output logic                      blink_status
);
    localparam int PORTS = BYTE_W + EXTRA_W;

    logic              pin_lvl;
    phase_e            phase;
    logic [PORTS-1:0]  img0;
    logic [PORTS-1:0]  img1;

    blink_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (blink_pin),
        .q     (pin_lvl)
    );

    blink_phase_calc u_phase (
        .pin_lvl (pin_lvl),
        .ctl     (ctl),
        .phase   (phase)
    );

    // Assemble each phase image: byte pattern low, configuration bits high.
    always_comb begin
        img0 = {hi_phase0, phase0_byte};
        img1 = {hi_phase1, phase1_byte};
    end

    blink_port_mux #(.PORTS(PORTS)) u_mux (
        .phase (phase),
        .img0  (img0),
        .img1  (img1),
        .sel   (port_rel)
    );

    assign blink_status = pin_lvl;
endmodule

// File: rtl/blink_phase_selector_chk.sv
// Module: blink_phase_selector_chk
// Assertion checker bound to blink_phase_selector. Observes ports only.
// Assumes a two-stage synchronizer (default SYNC_STAGES).
module blink_phase_selector_chk #(
    parameter int BYTE_W  = 8,
    parameter int EXTRA_W = 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      blink_pin,
    input logic [1:0]                ctl,
    input logic [BYTE_W-1:0]         phase0_byte,
    input logic [BYTE_W-1:0]         phase1_byte,
    input logic [EXTRA_W-1:0]        hi_phase0,
    input logic [EXTRA_W-1:0]        hi_phase1,
    input logic [BYTE_W+EXTRA_W-1:0] port_rel,
    input logic                      blink_status
);
    logic [1:0] age;

    // Count clocks since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assert_static_phase0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[0] |-> port_rel == {hi_phase0, phase0_byte});

    assert_xor_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[0] |-> port_rel == ((blink_status ^ ctl[1]) ? {hi_phase1, phase1_byte}
                                                       : {hi_phase0, phase0_byte}));

    assert_ninth_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[0] && (blink_status ^ ctl[1])) |-> port_rel[BYTE_W] == hi_phase1[0]);

    assert_status_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> blink_status == $past(blink_pin, 2));

    assert_status_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(blink_pin, 2) == $past(blink_pin, 3)) |-> $stable(blink_status));

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> blink_status == 1'b0);
endmodule

bind blink_phase_selector blink_phase_selector_chk #(
    .BYTE_W  (BYTE_W),
    .EXTRA_W (EXTRA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .blink_pin    (blink_pin),
    .ctl          (ctl),
    .phase0_byte  (phase0_byte),
    .phase1_byte  (phase1_byte),
    .hi_phase0    (hi_phase0),
    .hi_phase1    (hi_phase1),
    .port_rel     (port_rel),
    .blink_status (blink_status)
);

// File: tb/sim_blink_phase_selector.sv
// Bench: sweeps pin, control and pattern combinations and pin-edge latency.
module sim_blink_phase_selector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blink_pin = 1'b0;
    logic [1:0] ctl = 2'b00;
    logic [7:0] phase0_byte = 8'hFF;
    logic [7:0] phase1_byte = 8'hFF;
    logic [0:0] hi_phase0 = 1'b1;
    logic [0:0] hi_phase1 = 1'b1;
    logic [8:0] port_rel;
    logic       blink_status;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    blink_phase_selector u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .blink_pin    (blink_pin),
        .ctl          (ctl),
        .phase0_byte  (phase0_byte),
        .phase1_byte  (phase1_byte),
        .hi_phase0    (hi_phase0),
        .hi_phase1    (hi_phase1),
        .port_rel     (port_rel),
        .blink_status (blink_status)
    );

    function automatic logic [8:0] model(input logic pin_s, input logic [1:0] c,
                                         input logic [7:0] p0, input logic [7:0] p1,
                                         input logic h0, input logic h1);
        logic ph;
        ph = c[0] & (pin_s ^ c[1]);
        return ph ? {h1, p1} : {h0, p0};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R7: reset clears status, phase 0 shown with enable on and pin high
        blink_pin = 1'b1; ctl = 2'b01;
        phase0_byte = 8'h3C; phase1_byte = 8'hC3; hi_phase0 = 1'b0; hi_phase1 = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 status", {8'd0, blink_status}, 9'd0);
        check("R7 outputs", port_rel, 9'h03C);
        @(negedge clk);
        rst_n = 1'b1;
        blink_pin = 1'b0;
        repeat (3) @(negedge clk);

        // R1 R2 R3 R4 R5: sweep pin, control and patterns
        for (int pin = 0; pin < 2; pin++) begin
            blink_pin = pin[0];
            repeat (3) @(negedge clk);
            check("R5 status", {8'd0, blink_status}, {8'd0, pin[0]});
            for (int c = 0; c < 4; c++) begin
                for (int k = 0; k < 8; k++) begin
                    ctl = c[1:0];
                    phase0_byte = 8'hA5 ^ 8'(k * 37);
                    phase1_byte = ~{phase0_byte[3:0], phase0_byte[7:4]} ^ 8'(k);
                    hi_phase0 = k[0];
                    hi_phase1 = k[1];
                    #2;
                    check(c[0] ? "R2 R3 R4 blink" : "R1 R3 R4 static", port_rel,
                          model(pin[0], ctl, phase0_byte, phase1_byte, hi_phase0, hi_phase1));
                    check("R5 status any mode", {8'd0, blink_status}, {8'd0, pin[0]});
                    @(negedge clk);
                end
            end
        end

        // R6: pin edge latency and no dropped phases
        ctl = 2'b01; phase0_byte = 8'h00; phase1_byte = 8'hFF;
        hi_phase0 = 1'b0; hi_phase1 = 1'b1;
        @(negedge clk);
        for (int n = 0; n < 12; n++) begin
            logic old_lvl;
            logic new_lvl;
            old_lvl = blink_pin;
            new_lvl = ~blink_pin;
            blink_pin = new_lvl;
            @(negedge clk);
            check("R6 not yet", port_rel, {9{old_lvl}});
            @(negedge clk);
            check("R6 taken", port_rel, {9{new_lvl}});
            check("R6 status", {8'd0, blink_status}, {8'd0, new_lvl});
        end

        // R2: flip inverts the phase with pin held
        ctl = 2'b11;
        #2;
        check("R2 flip", port_rel, {9{~blink_status}});

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule